// File: doc/BRIEF.md
# Tuple-Selected Instruction Decode Router

This block keeps, for every hart, a writable identity pair made of a vendor identifier and an architecture identifier. The pair that a hart currently holds names one entry in a parameterized table of legal pairs. Each table entry stands for one decode engine and one trap-handler set. The block turns that choice into a one-hot enable for the engines and qualifies each engine's opcode match with its own enable bit. One binary encoding can therefore be decoded by a different engine depending on the pair in force.

Software changes the pair through a small CSR port. A vendor-identifier write is only staged. The pair changes when the next architecture-identifier write arrives, and only if the combined pair appears in the legal table. A committed change moves the trap vector base at once. It then stalls decode on that hart for two cycles before the new engine takes over. A build parameter can freeze the pair at the first table entry. That build has no custom extensions, and it ignores writes.

Top module: `tdr_router`

## Requirements
- R1: After reset, every hart holds table entry 0: reads return vendor 0x11 and architecture 0x01 (default table), engine bit 0 is enabled, the trap base is 0x1000 and stall is low.
- R2: A write with `csr_sel`=0 (vendor) only stages the value, and reads keep returning the committed pair. A write with `csr_sel`=1 (architecture) forms the candidate pair from the staged vendor value, or the committed vendor value if none is staged, together with the written data. It commits the candidate at that clock edge if the pair is legal. An architecture write always clears the staged value.
- R3: A candidate pair that is not in the legal table is discarded, and both committed values stay as they were. Reads therefore only ever return legal pairs.
- R4: Exactly one bit of `eng_en` is high. Bit k is high when the active pair of the decoding hart is table entry k.
- R5: While not stalled, `dec_valid` is high in the same cycle when `insn_valid` is high and the enabled engine's `eng_match` bit is set. `dec_sel` gives the active entry index. Match bits of engines that are not enabled have no effect.
- R6: While not stalled, `insn_valid` with no match from the enabled engine raises `dec_illegal` instead of `dec_valid`. The two flags are never high together.
- R7: Each hart's pair, staging and stall are independent. A write to one hart changes no other hart's pair, stall or enable.
- R8: `trap_entry` leaves every committed pair unchanged. It discards any vendor value staged on `trap_hart`, so a later architecture write pairs with the committed vendor value.
- R9: `trap_base` shows the trap-handler base of the committed pair of `trap_hart`. It moves to the new entry's base in the first cycle after the commit (defaults 0x1000, 0x2000, 0x3000 and 0x4000 for entries 0 to 3).
- R10: A commit that changes a hart's entry raises `stall` for that hart for exactly two cycles. During those cycles neither `dec_valid` nor `dec_illegal` is raised and the old enable stays. The new enable applies from the first cycle without stall. A commit of the pair already held causes no stall.
- R11: With `WRITABLE`=0 every hart stays on entry 0 and all writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| csr_we | input | 1 | CSR write strobe |
| csr_sel | input | 1 | 0 selects the vendor identifier, 1 the architecture identifier |
| csr_hart | input | HART_W (1) | Hart addressed by the CSR port |
| csr_wdata | input | ID_W (8) | Write data |
| csr_rdata | output | ID_W (8) | Committed identifier of the addressed hart |
| insn_valid | input | 1 | An instruction is presented for decode |
| dec_hart | input | HART_W (1) | Hart whose instruction is decoded |
| eng_match | input | NUM_ENG (4) | Opcode match from each decode engine |
| eng_en | output | NUM_ENG (4) | One-hot engine enable for the decoding hart |
| dec_valid | output | 1 | Enabled engine decoded the instruction |
| dec_illegal | output | 1 | Enabled engine did not recognise the instruction |
| dec_sel | output | IDX_W (2) | Index of the enabled engine |
| stall | output | 1 | Decoding hart is switching engines |
| trap_entry | input | 1 | Trap taken on `trap_hart` |
| trap_hart | input | HART_W (1) | Hart entering a trap, and hart whose trap base is shown |
| trap_base | output | ADDR_W (32) | Trap-handler base of that hart's committed pair |

## Verification
The checker assumes that the legal table is free of duplicate pairs and that the decoding hart selectors stay in range. It also assumes that `trap_entry` and a CSR write to the same hart do not meet in one cycle, because the stability property on the committed pairs excludes only CSR-write cycles. The stimulus drives every input from one sequential flow, at most one CSR operation per cycle. It raises `trap_entry` only in cycles without a write, and it keeps every hart number below the hart count, so those premises hold throughout.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
  typedef enum logic {
    SEL_VENDOR = 1'b0,
    SEL_ARCH   = 1'b1
  } id_sel_e;

  localparam int STALL_CYCLES = 2;
endpackage

// File: rtl/tdr_tuple_lookup.sv
module tdr_tuple_lookup #(
  parameter int NUM_ENG = 4,
  parameter int ID_W    = 8,
  parameter logic [NUM_ENG*ID_W-1:0] VID_TBL = '0,
  parameter logic [NUM_ENG*ID_W-1:0] AID_TBL = '0,
  localparam int IDX_W = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1
) (
  input  logic [ID_W-1:0]  vid,
  input  logic [ID_W-1:0]  aid,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  // Scan from the top entry down so the lowest matching entry wins.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int k = NUM_ENG - 1; k >= 0; k--) begin
      if (VID_TBL[k*ID_W +: ID_W] == vid && AID_TBL[k*ID_W +: ID_W] == aid) begin
        hit = 1'b1;
        idx = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/tdr_hart_ctx.sv
module tdr_hart_ctx
  import tdr_pkg::*;
#(
  parameter int NUM_ENG  = 4,
  parameter int ID_W     = 8,
  parameter bit WRITABLE = 1'b1,
  parameter logic [NUM_ENG*ID_W-1:0] VID_TBL = '0,
  parameter logic [NUM_ENG*ID_W-1:0] AID_TBL = '0,
  localparam int IDX_W = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1,
  localparam int CNT_W = $clog2(STALL_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  id_sel_e          wr_sel,
  input  logic [ID_W-1:0]  wr_data,
  input  logic             trap_hit,
  output logic [IDX_W-1:0] cur_idx,
  output logic [IDX_W-1:0] act_idx,
  output logic             stall
);
  logic             stg_vld_q, stg_vld_n;
  logic [ID_W-1:0]  stg_vid_q, stg_vid_n;
  logic [IDX_W-1:0] cur_q, cur_n, act_q, act_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [ID_W-1:0]  cand_vid;
  logic             cand_hit;
  logic [IDX_W-1:0] cand_idx;
  logic             wr_ok, commit_chg;

  assign wr_ok    = WRITABLE && wr_en;
  assign cand_vid = stg_vld_q ? stg_vid_q : VID_TBL[cur_q*ID_W +: ID_W];

  tdr_tuple_lookup #(
    .NUM_ENG(NUM_ENG), .ID_W(ID_W), .VID_TBL(VID_TBL), .AID_TBL(AID_TBL)
  ) u_lookup (
    .vid(cand_vid), .aid(wr_data), .hit(cand_hit), .idx(cand_idx)
  );

  assign commit_chg = wr_ok && (wr_sel == SEL_ARCH) && cand_hit && (cand_idx != cur_q);

  always_comb begin
    stg_vld_n = stg_vld_q;
    stg_vid_n = stg_vid_q;
    cur_n     = cur_q;
    act_n     = act_q;
    cnt_n     = cnt_q;
    if (wr_ok) begin
      if (wr_sel == SEL_VENDOR) begin
        stg_vld_n = 1'b1;
        stg_vid_n = wr_data;
      end else begin
        stg_vld_n = 1'b0;
      end
    end else if (trap_hit) begin
      stg_vld_n = 1'b0;
    end
    if (commit_chg) begin
      cur_n = cand_idx;
      cnt_n = CNT_W'(STALL_CYCLES);
    end else if (cnt_q != '0) begin
      cnt_n = cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) act_n = cur_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_vld_q <= 1'b0;
      stg_vid_q <= '0;
      cur_q     <= '0;
      act_q     <= '0;
      cnt_q     <= '0;
    end else begin
      stg_vld_q <= stg_vld_n;
      stg_vid_q <= stg_vid_n;
      cur_q     <= cur_n;
      act_q     <= act_n;
      cnt_q     <= cnt_n;
    end
  end

  assign cur_idx = cur_q;
  assign act_idx = act_q;
  assign stall   = (cnt_q != '0);
endmodule

// File: rtl/tdr_router.sv
module tdr_router
  import tdr_pkg::*;
#(
  parameter int NUM_HARTS = 2,
  parameter int NUM_ENG   = 4,
  parameter int ID_W      = 8,
  parameter int ADDR_W    = 32,
  parameter bit WRITABLE  = 1'b1,
  parameter logic [NUM_ENG*ID_W-1:0]   VID_TBL  = {8'h33, 8'h22, 8'h11, 8'h11},
  parameter logic [NUM_ENG*ID_W-1:0]   AID_TBL  = {8'h07, 8'h01, 8'h02, 8'h01},
  parameter logic [NUM_ENG*ADDR_W-1:0] TRAP_TBL = {32'h4000, 32'h3000, 32'h2000, 32'h1000},
  localparam int IDX_W  = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1,
  localparam int HART_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic              csr_sel,
  input  logic [HART_W-1:0] csr_hart,
  input  logic [ID_W-1:0]   csr_wdata,
  output logic [ID_W-1:0]   csr_rdata,
  input  logic              insn_valid,
  input  logic [HART_W-1:0] dec_hart,
  input  logic [NUM_ENG-1:0] eng_match,
  output logic [NUM_ENG-1:0] eng_en,
  output logic              dec_valid,
  output logic              dec_illegal,
  output logic [IDX_W-1:0]  dec_sel,
  output logic              stall,
  input  logic              trap_entry,
  input  logic [HART_W-1:0] trap_hart,
  output logic [ADDR_W-1:0] trap_base
);
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  logic [IDX_W-1:0] cur_idx [NUM_HARTS];
  logic [IDX_W-1:0] act_idx [NUM_HARTS];
  logic [NUM_HARTS-1:0] hart_stall;
  logic [NUM_HARTS*IDX_W-1:0] cur_flat;

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    tdr_hart_ctx #(
      .NUM_ENG(NUM_ENG), .ID_W(ID_W), .WRITABLE(WRITABLE),
      .VID_TBL(VID_TBL), .AID_TBL(AID_TBL)
    ) u_ctx (
      .clk      (clk),
      .rst_n    (rst_s2_q),
      .wr_en    (csr_we && (csr_hart == HART_W'(h))),
      .wr_sel   (id_sel_e'(csr_sel)),
      .wr_data  (csr_wdata),
      .trap_hit (trap_entry && (trap_hart == HART_W'(h))),
      .cur_idx  (cur_idx[h]),
      .act_idx  (act_idx[h]),
      .stall    (hart_stall[h])
    );
    assign cur_flat[h*IDX_W +: IDX_W] = cur_idx[h];
  end

  logic [IDX_W-1:0] rd_idx, tb_idx;
  logic             hit_any;

  assign rd_idx    = cur_idx[csr_hart];
  assign csr_rdata = csr_sel ? AID_TBL[rd_idx*ID_W +: ID_W] : VID_TBL[rd_idx*ID_W +: ID_W];
  assign tb_idx    = cur_idx[trap_hart];
  assign trap_base = TRAP_TBL[tb_idx*ADDR_W +: ADDR_W];

  assign dec_sel     = act_idx[dec_hart];
  assign stall       = hart_stall[dec_hart];
  assign eng_en      = NUM_ENG'(1) << dec_sel;
  assign hit_any     = |(eng_match & eng_en);
  assign dec_valid   = insn_valid && !stall && hit_any;
  assign dec_illegal = insn_valid && !stall && !hit_any;
endmodule

// File: rtl/tdr_router_chk.sv
module tdr_router_chk #(
  parameter int NUM_HARTS = 2,
  parameter int NUM_ENG   = 4,
  parameter int IDX_W     = 2,
  parameter int HART_W    = 1,
  parameter bit WRITABLE  = 1'b1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       csr_we,
  input logic [HART_W-1:0]          csr_hart,
  input logic                       trap_entry,
  input logic                       stall,
  input logic                       dec_valid,
  input logic                       dec_illegal,
  input logic [NUM_ENG-1:0]         eng_en,
  input logic [NUM_HARTS*IDX_W-1:0] cur_flat
);
  a_r4_one_engine: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(eng_en) == 1);

  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_valid && dec_illegal));

  a_r10_quiet_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!dec_valid && !dec_illegal));

  a_r8_trap_keeps_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_entry && !csr_we) |=> $stable(cur_flat));

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_h
    a_r7_other_hart_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (!csr_we || csr_hart != HART_W'(h)) |=> $stable(cur_flat[h*IDX_W +: IDX_W]));
  end

  if (!WRITABLE) begin : g_ro
    a_r11_ro_pair_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      csr_we |=> $stable(cur_flat));
  end
endmodule

bind tdr_router tdr_router_chk #(
  .NUM_HARTS(NUM_HARTS), .NUM_ENG(NUM_ENG), .IDX_W(IDX_W),
  .HART_W(HART_W), .WRITABLE(WRITABLE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_hart(csr_hart),
  .trap_entry(trap_entry), .stall(stall), .dec_valid(dec_valid),
  .dec_illegal(dec_illegal), .eng_en(eng_en), .cur_flat(cur_flat)
);

// File: tb/tb_tdr_router.sv
module tb_tdr_router;
  localparam int K_RDATA = 0, K_ENGEN = 1, K_VALID = 2, K_ILL = 3,
                 K_SEL = 4, K_STALL = 5, K_TBASE = 6, K_RO = 7;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, csr_we, csr_sel, insn_valid, trap_entry;
  logic [0:0]  csr_hart, dec_hart, trap_hart;
  logic [7:0]  csr_wdata, csr_rdata, ro_rdata;
  logic [3:0]  eng_match, eng_en, ro_eng_en;
  logic        dec_valid, dec_illegal, stall, ro_valid, ro_ill, ro_stall;
  logic [1:0]  dec_sel, ro_sel;
  logic [31:0] trap_base, ro_tbase;

  tdr_router dut (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_hart(csr_hart), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .insn_valid(insn_valid), .dec_hart(dec_hart), .eng_match(eng_match),
    .eng_en(eng_en), .dec_valid(dec_valid), .dec_illegal(dec_illegal),
    .dec_sel(dec_sel), .stall(stall), .trap_entry(trap_entry),
    .trap_hart(trap_hart), .trap_base(trap_base)
  );

  tdr_router #(.WRITABLE(1'b0)) dut_ro (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_hart(csr_hart), .csr_wdata(csr_wdata), .csr_rdata(ro_rdata),
    .insn_valid(insn_valid), .dec_hart(dec_hart), .eng_match(eng_match),
    .eng_en(ro_eng_en), .dec_valid(ro_valid), .dec_illegal(ro_ill),
    .dec_sel(ro_sel), .stall(ro_stall), .trap_entry(trap_entry),
    .trap_hart(trap_hart), .trap_base(ro_tbase)
  );

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  function automatic logic [31:0] actual(int kind);
    case (kind)
      K_RDATA: return 32'(csr_rdata);
      K_ENGEN: return 32'(eng_en);
      K_VALID: return 32'(dec_valid);
      K_ILL:   return 32'(dec_illegal);
      K_SEL:   return 32'(dec_sel);
      K_STALL: return 32'(stall);
      K_TBASE: return trap_base;
      default: return 32'(ro_rdata);
    endcase
  endfunction

  // Monitor: pops and compares at the falling edge.
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] a;
      it = q.pop_front();
      a = actual(it.kind);
      n_chk++;
      if (a !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind %0d: actual %h expected %h", it.req, it.kind, a, it.exp);
      end
    end
  end

  task automatic chk(int kind, logic [31:0] exp, string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    csr_we = 1'b0;
    trap_entry = 1'b0;
  endtask

  task automatic wr(logic [0:0] h, logic sel, logic [7:0] d);
    csr_hart = h; csr_sel = sel; csr_wdata = d; csr_we = 1'b1;
    cyc();
  endtask

  task automatic rd(logic [0:0] h, logic sel, logic [7:0] exp, string req);
    csr_hart = h; csr_sel = sel;
    chk(K_RDATA, 32'(exp), req);
    cyc();
  endtask

  initial begin
    rst_n = 1'b0; csr_we = 0; csr_sel = 0; csr_hart = 0; csr_wdata = 0;
    insn_valid = 0; dec_hart = 0; eng_match = 0; trap_entry = 0; trap_hart = 0;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (4) cyc();

    // R1 reset state
    chk(K_ENGEN, 32'h1, "R1"); chk(K_STALL, 0, "R1"); chk(K_TBASE, 32'h1000, "R1");
    rd(0, 0, 8'h11, "R1");
    rd(0, 1, 8'h01, "R1");

    // R5 / R6 decode on entry 0
    insn_valid = 1; eng_match = 4'b0001;
    chk(K_VALID, 1, "R5"); chk(K_ILL, 0, "R5"); chk(K_SEL, 0, "R5"); cyc();
    eng_match = 4'b0010;
    chk(K_VALID, 0, "R6"); chk(K_ILL, 1, "R6"); cyc();
    eng_match = 4'b1111;
    chk(K_VALID, 1, "R5"); chk(K_SEL, 0, "R5"); cyc();
    insn_valid = 0; eng_match = 4'b0001;
    chk(K_VALID, 0, "R5"); chk(K_ILL, 0, "R5"); cyc();

    // R2 staged vendor, commit on arch write -> entry 2
    wr(0, 0, 8'h22);
    rd(0, 0, 8'h11, "R2");
    wr(0, 1, 8'h01);
    insn_valid = 1; eng_match = 4'b0100;
    chk(K_STALL, 1, "R10"); chk(K_TBASE, 32'h3000, "R9");
    chk(K_VALID, 0, "R10"); chk(K_ILL, 0, "R10"); chk(K_ENGEN, 32'h1, "R10");
    rd(0, 0, 8'h22, "R2");
    chk(K_STALL, 1, "R10");
    rd(0, 1, 8'h01, "R2");
    chk(K_STALL, 0, "R10"); chk(K_ENGEN, 32'h4, "R4");
    chk(K_VALID, 1, "R5"); chk(K_SEL, 2, "R5"); cyc();
    eng_match = 4'b0001;
    chk(K_ILL, 1, "R6"); chk(K_VALID, 0, "R6"); cyc();
    insn_valid = 0;

    // R3 illegal pairs discarded
    wr(0, 0, 8'h33);
    wr(0, 1, 8'h01);
    chk(K_STALL, 0, "R3");
    rd(0, 0, 8'h22, "R3");
    rd(0, 1, 8'h01, "R3");
    wr(0, 1, 8'h02);
    rd(0, 1, 8'h01, "R3");
    rd(0, 0, 8'h22, "R3");

    // R7 hart 1 independent, arch-only write uses committed vendor
    wr(1, 1, 8'h02);
    dec_hart = 1; chk(K_STALL, 1, "R10");
    rd(1, 1, 8'h02, "R2");
    dec_hart = 0; trap_hart = 1;
    chk(K_STALL, 0, "R7"); chk(K_TBASE, 32'h2000, "R9");
    rd(0, 0, 8'h22, "R7");
    cyc();
    dec_hart = 1; chk(K_ENGEN, 32'h2, "R7"); cyc();
    dec_hart = 0; chk(K_ENGEN, 32'h4, "R7"); cyc();

    // R10 same pair again: no stall
    wr(1, 1, 8'h02);
    dec_hart = 1; chk(K_STALL, 0, "R10"); cyc();

    // R8 trap keeps pair and drops staged vendor
    wr(1, 0, 8'h22);
    trap_entry = 1; trap_hart = 1; cyc();
    rd(1, 0, 8'h11, "R8");
    rd(1, 1, 8'h02, "R8");
    wr(1, 1, 8'h01);
    rd(1, 0, 8'h11, "R8");
    chk(K_TBASE, 32'h1000, "R9"); cyc();

    // R11 read-only build ignored all writes
    csr_hart = 0; csr_sel = 0;
    chk(K_RO, 32'h11, "R11"); chk(K_RDATA, 32'h22, "R11"); cyc();
    csr_sel = 1; chk(K_RO, 32'h01, "R11"); cyc();

    repeat (3) cyc();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule